// File: doc/BRIEF.md
# UART Line Format and Baud Tick Generator

This block holds the three configuration registers that shape a UART's serial line: a line-format register, an integer baud divisor and a 3-bit fractional addend. From them it derives the framing settings used by a transmitter and a receiver (data length, stop-bit count, parity on/off and sense, infrared flag). It also derives a 16x oversampling tick from a 24 MHz reference clock, which is the block clock. The serializers that consume these outputs sit outside the block.

The target bit period is 16 × (divisor + 1) + frac reference cycles. Each bit period is split into 16 tick intervals of divisor + 1 cycles. The first `frac` intervals of every bit period are one cycle longer, so the average rate is exact and no interval is ever shorter than divisor + 1.

Every accepted write to one of the three registers re-evaluates the framing. When the divisor in effect after the write is zero, the framing outputs keep their previous values and the tick stops. A write to the integer or fractional divisor restarts the tick counter, so no shortened interval is produced.

Top module: `uart_line_baud`

## Requirements
- R1: After reset the framing outputs report 5 data bits, one stop bit, parity off, parity sense odd and infrared off, and no tick is produced.
- R2: Once applied, the data-length output equals line-format bits [1:0] plus 5, so its range is 5 to 8.
- R3: Once applied, the two-stop output equals line-format bit 2 (1 = two stop bits, 0 = one).
- R4: Once applied, the parity-enable output equals line-format bit 5. The parity-even output equals bit 3 while bit 5 is set (1 = even, 0 = odd) and is 0 while parity is off.
- R5: Once applied, the infrared output equals line-format bit 6.
- R6: A write to address 0 (line format), 1 (integer divisor, low DIV_W bits) or 2 (fractional, bits [2:0]) applies the stored line format one cycle later, but only if the integer divisor in effect after that write is nonzero. Otherwise all framing outputs hold.
- R7: While the integer divisor is zero, the tick output stays low.
- R8: With divisor D and fraction F, the k-th tick interval of a bit period (k = 0..15) lasts D + 1 + (k < F ? 1 : 0) cycles. The tick is a single-cycle pulse.
- R9: Any 16 consecutive tick intervals that start at a bit-period boundary add up to 16 × D + F + 16 cycles.
- R10: After a write to address 1 or 2, the first tick comes exactly D + 1 + (F > 0 ? 1 : 0) clock edges after the write edge, and it starts a new bit period.
- R11: A write to address 0 does not disturb the spacing of the tick stream.
- R12: A write to address 3 changes neither the framing outputs nor the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 line format, 1 integer divisor, 2 fraction, 3 unused |
| wr_data | input | max(DIV_W,7) | Write data |
| data_bits_o | output | 4 | Data length, 5 to 8 |
| two_stop_o | output | 1 | Two stop bits selected |
| parity_en_o | output | 1 | Parity generation and checking on |
| parity_even_o | output | 1 | Even parity (valid with parity on) |
| ir_mode_o | output | 1 | Infrared line mode flag |
| tick_o | output | 1 | 16x oversampling pulse |

## Verification
The bench builds the block with DIV_W = 6. This makes the all-ones divisor of 63 reachable, giving bit periods of up to 1031 cycles, so the longest interval and the widest counter value are exercised within the cycle budget. The same setting makes the write bus 7 bits wide, which is exactly the line-format field. Random divisors and fractions across the full 6-bit and 3-bit ranges cover every tick length pattern. Directed cases cover a zero divisor, the fraction at 0 and at 7, and writes in the middle of a tick interval.

// File: rtl/uart_line_baud_pkg.sv
package uart_line_baud_pkg;

    localparam int FRAC_W = 3;
    localparam int LINE_W = 7;

    typedef enum logic [1:0] {
        SEL_LINE = 2'd0,
        SEL_DIVI = 2'd1,
        SEL_DIVF = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       ir;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_line(input logic [LINE_W-1:0] lc);
        frame_cfg_t c;
        c.data_bits = 4'd5 + {2'b00, lc[1:0]};
        c.two_stop  = lc[2];
        c.par_en    = lc[5];
        c.par_even  = lc[5] & lc[3];
        c.ir        = lc[6];
        return c;
    endfunction

endpackage

// File: rtl/uart_line_baud_regs.sv
module uart_line_baud_regs
    import uart_line_baud_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_o,
    output logic [FRAC_W-1:0] frac_o,
    output frame_cfg_t       cfg_o,
    output logic             reload_o
);

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] frac;
        frame_cfg_t        cfg;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel      = reg_sel_e'(wr_addr);
        st_d     = st_q;
        reload_o = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_LINE: st_d.line = wr_data[LINE_W-1:0];
                SEL_DIVI: begin
                    st_d.div = wr_data[DIV_W-1:0];
                    reload_o = 1'b1;
                end
                SEL_DIVF: begin
                    st_d.frac = wr_data[FRAC_W-1:0];
                    reload_o  = 1'b1;
                end
                default: ;
            endcase
            if (sel != SEL_NONE && st_d.div != '0) begin
                st_d.cfg = decode_line(st_d.line);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.line <= '0;
            st_q.div  <= '0;
            st_q.frac <= '0;
            st_q.cfg  <= decode_line('0);
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o  = st_q.div;
    assign frac_o = st_q.frac;
    assign cfg_o  = st_q.cfg;

endmodule

// File: rtl/uart_line_baud_tickgen.sv
module uart_line_baud_tickgen
    import uart_line_baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              reload_i,
    output logic              tick_o
);

    localparam int CNT_W = DIV_W + 1;
    localparam int SUB_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic             tick;
    } tg_t;

    tg_t              st_d, st_q;
    logic             stretch;
    logic [CNT_W-1:0] term;

    always_comb begin
        stretch = (st_q.sub < {1'b0, frac_i});
        term    = {1'b0, div_i} + CNT_W'(stretch);
        st_d    = st_q;
        if (reload_i || div_i == '0) begin
            st_d.cnt  = '0;
            st_d.sub  = '0;
            st_d.tick = 1'b0;
        end else if (st_q.cnt == term) begin
            st_d.cnt  = '0;
            st_d.sub  = st_q.sub + 1'b1;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/uart_line_baud.sv
module uart_line_baud
    import uart_line_baud_pkg::*;
#(
    parameter  int DIV_W = 16,
    localparam int BUS_W = (DIV_W > LINE_W) ? DIV_W : LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    output logic [3:0]       data_bits_o,
    output logic             two_stop_o,
    output logic             parity_en_o,
    output logic             parity_even_o,
    output logic             ir_mode_o,
    output logic             tick_o
);

    logic [DIV_W-1:0]  div_w;
    logic [FRAC_W-1:0] frac_w;
    frame_cfg_t        cfg_w;
    logic              reload_w;

    uart_line_baud_regs #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .div_o    (div_w),
        .frac_o   (frac_w),
        .cfg_o    (cfg_w),
        .reload_o (reload_w)
    );

    uart_line_baud_tickgen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (div_w),
        .frac_i   (frac_w),
        .reload_i (reload_w),
        .tick_o   (tick_o)
    );

    assign data_bits_o   = cfg_w.data_bits;
    assign two_stop_o    = cfg_w.two_stop;
    assign parity_en_o   = cfg_w.par_en;
    assign parity_even_o = cfg_w.par_even;
    assign ir_mode_o     = cfg_w.ir;

endmodule

// File: rtl/uart_line_baud_chk.sv
module uart_line_baud_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [DIV_W-1:0] wr_div,
    input logic [DIV_W-1:0] div_i,
    input logic [3:0]       data_bits,
    input logic             two_stop,
    input logic             par_en,
    input logic             par_even,
    input logic             ir,
    input logic             tick
);

    logic [7:0] cfg_bus;
    assign cfg_bus = {data_bits, two_stop, par_en, par_even, ir};

    AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_bits >= 4'd5 && data_bits <= 4'd8)); // R2

    AST_EVEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        par_even |-> par_en); // R4

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_bus)); // R6

    AST_HOLD_LINE_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && div_i == '0) |=> $stable(cfg_bus)); // R6

    AST_HOLD_DIV_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_div == '0) |=> $stable(cfg_bus)); // R6

    AST_NO_TICK_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |=> !tick); // R7

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R8

    AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd1 || wr_addr == 2'd2)) |=> !tick); // R10

    AST_ADDR3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> $stable(cfg_bus)); // R12

endmodule

bind uart_line_baud uart_line_baud_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_div    (wr_data[DIV_W-1:0]),
    .div_i     (div_w),
    .data_bits (data_bits_o),
    .two_stop  (two_stop_o),
    .par_en    (parity_en_o),
    .par_even  (parity_even_o),
    .ir        (ir_mode_o),
    .tick      (tick_o)
);

// File: tb/uart_line_baud_test.sv
module uart_line_baud_test;

    localparam int DIV_W = 6;
    localparam int BUS_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [BUS_W-1:0] wr_data = '0;
    logic [3:0]       data_bits_o;
    logic             two_stop_o, parity_en_o, parity_even_o, ir_mode_o, tick_o;

    int checks = 0;
    int fails  = 0;

    logic [6:0] line_m = '0;
    logic [6:0] applied_m = '0;
    int         div_m = 0;
    int         frac_m = 0;

    always #2 clk = ~clk;

    uart_line_baud #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .data_bits_o(data_bits_o), .two_stop_o(two_stop_o), .parity_en_o(parity_en_o),
        .parity_even_o(parity_even_o), .ir_mode_o(ir_mode_o), .tick_o(tick_o)
    );

    function automatic logic [7:0] exp_cfg(input logic [6:0] lc);
        logic [3:0] db;
        db = 4'd5 + {2'b00, lc[1:0]};
        return {db, lc[2], lc[5], lc[5] & lc[3], lc[6]};
    endfunction

    function automatic int exp_len(input int d, input int f, input int k);
        return d + 1 + (((k % 16) < f) ? 1 : 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_cfg(input string req);
        logic [7:0] act, exp;
        act = {data_bits_o, two_stop_o, parity_en_o, parity_even_o, ir_mode_o};
        exp = exp_cfg(applied_m);
        check(act == exp, req, int'(act), int'(exp));
    endtask

    // drive one write; returns 1 time unit after the write edge
    task automatic bus_write(input logic [1:0] a, input logic [BUS_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        case (a)
            2'd0: line_m = d[6:0];
            2'd1: div_m = int'(d[DIV_W-1:0]);
            2'd2: frac_m = int'(d[2:0]);
            default: ;
        endcase
        if (a != 2'd3 && div_m != 0) applied_m = line_m;
    endtask

    // measure n tick intervals, starting at interval index k0 of a bit period
    task automatic measure(input int n, input int k0, input string req, input bit sum16);
        int total = 0;
        for (int k = 0; k < n; k++) begin
            int cnt = 0;
            do begin
                @(posedge clk);
                #1;
                cnt++;
            end while (!tick_o && cnt < 3000);
            total += cnt;
            check(cnt == exp_len(div_m, frac_m, k0 + k), req, cnt, exp_len(div_m, frac_m, k0 + k));
        end
        if (sum16)
            check(total == 16 * div_m + frac_m + 16, "R9", total, 16 * div_m + frac_m + 16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check_cfg("R1");
        begin
            bit seen = 1'b0;
            repeat (40) begin @(posedge clk); #1; if (tick_o) seen = 1'b1; end
            check(!seen, "R1", int'(seen), 0);
        end

        // R6: line write with zero divisor holds outputs
        bus_write(2'd0, 7'h7F);
        check_cfg("R6");
        check(data_bits_o == 4'd5, "R6", data_bits_o, 5);
        // applying through a divisor write
        bus_write(2'd1, 7'd3);
        check_cfg("R6");
        check(data_bits_o == 4'd8 && two_stop_o && parity_en_o && parity_even_o && ir_mode_o,
              "R2", data_bits_o, 8);

        // R2..R5 directed patterns
        bus_write(2'd0, 7'h20); check_cfg("R4"); check(parity_en_o && !parity_even_o, "R4", parity_even_o, 0);
        bus_write(2'd0, 7'h08); check_cfg("R4"); check(!parity_en_o && !parity_even_o, "R4", parity_en_o, 0);
        bus_write(2'd0, 7'h05); check_cfg("R3"); check(two_stop_o && data_bits_o == 4'd6, "R3", two_stop_o, 1);
        bus_write(2'd0, 7'h42); check_cfg("R5"); check(ir_mode_o && data_bits_o == 4'd7, "R5", ir_mode_o, 1);

        // R8/R9/R10: frac 0 then full fraction, from reload
        bus_write(2'd2, 7'd0);
        measure(16, 0, "R10", 1'b1);
        bus_write(2'd2, 7'd7);
        measure(16, 0, "R8", 1'b1);
        bus_write(2'd1, 7'd63);
        measure(16, 0, "R8", 1'b1);
        bus_write(2'd1, 7'd1);
        bus_write(2'd2, 7'd5);
        measure(32, 0, "R9", 1'b0);

        // R11: line write in the middle of the tick stream
        bus_write(2'd1, 7'd9);
        bus_write(2'd2, 7'd3);
        fork
            measure(16, 0, "R11", 1'b1);
            begin
                repeat (14) @(posedge clk);
                bus_write(2'd0, 7'h2B);
            end
        join
        check_cfg("R11");

        // R12: address 3 ignored
        fork
            measure(16, 0, "R12", 1'b1);
            begin
                repeat (20) @(posedge clk);
                bus_write(2'd3, 7'h7F);
            end
        join
        check_cfg("R12");

        // R7: zero divisor stops the tick; outputs hold on the zero write
        bus_write(2'd1, 7'd0);
        check_cfg("R7");
        begin
            bit seen = 1'b0;
            repeat (300) begin @(posedge clk); #1; if (tick_o) seen = 1'b1; end
            check(!seen, "R7", int'(seen), 0);
        end
        bus_write(2'd2, 7'd6);
        check_cfg("R6");

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [1:0]       a;
            logic [BUS_W-1:0] d;
            a = 2'($urandom_range(0, 3));
            d = BUS_W'($urandom);
            bus_write(a, d);
            check_cfg("R6");
            if ((a == 2'd1 || a == 2'd2) && div_m != 0)
                measure(4, 0, "R8", 1'b0);
            else if (div_m == 0) begin
                bit seen = 1'b0;
                repeat (20) begin @(posedge clk); #1; if (tick_o) seen = 1'b1; end
                check(!seen, "R7", int'(seen), 0);
            end
        end

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule